// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block produces the column address for every beat of one read or write burst in a double-data-rate memory controller or memory model. A single-cycle start strobe captures a start column, a burst length code and an ordering bit. From the next clock on, the block presents one column address per cycle, marks the final beat, and then goes idle. Read and write bursts share the same captured length.

Every beat stays inside an aligned block of columns as large as the burst. The column bits above that block are held from the start column. The bits inside the block begin at the start column's low bits and either count upward with wrap-around or follow an XOR pattern with the beat index. A new strobe at any time abandons the running burst and starts the next one on the following clock.

Top module: `bcg_burst_addr_gen`

## Requirements
- R1: After reset, `beat_valid_o`, `last_o` and `busy_o` are low while `start_i` is low.
- R2: The length code `blen_code_i` captured at the strobe gives the beat count: 1 selects 2 beats, 2 selects 4, 3 selects 8, and the reserved code 0 is treated as 2. `last_o` is high on the final beat only, and `beat_valid_o` falls on the cycle after it.
- R3: When `btype_i` is 0 (sequential), the in-block bits of beat k equal (s + k) mod L, where s is the start column's in-block bits and L is the burst length.
- R4: When `btype_i` is 1 (interleaved), the in-block bits of beat k equal s XOR k.
- R5: Column bits at and above position log2(L) keep the start column's value on every beat, so a burst never leaves its aligned block.
- R6: Beat 0 is valid on the cycle after the strobe edge, and `col_o` equals the start column on that beat.
- R7: A strobe during a running burst ends it. The next cycle shows beat 0 of the new burst.
- R8: Changes to `start_col_i`, `blen_code_i` and `btype_i` while `start_i` is low do not affect a running burst.
- R9: `busy_o` is high in the strobe cycle and on every valid beat, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Start column address |
| blen_code_i | input | 2 | Burst length code (0/1: 2, 2: 4, 3: 8) |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | Strobe cycle or burst in progress |

## Verification
Two functions can land in the same cycle: the end of a burst and the launch of a new one. The end comes from the final beat. The launch comes from a strobe, either mid-burst or exactly on the final beat. The bench raises `start_i` on the third beat of an 8-beat burst, and also on the last beat of a 4-beat burst. It then checks that the next cycle shows beat 0 of the new burst with the new ordering and block, that no stale beat of the old burst appears, and that `busy_o` never drops between the two bursts.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int LG_MAX = 3;
    localparam int BEAT_W = LG_MAX;

    typedef enum logic {
        BT_SEQ   = 1'b0,
        BT_INTLV = 1'b1
    } burst_type_e;

    typedef struct packed {
        logic [1:0]  lg;
        burst_type_e btype;
    } burst_mode_t;

    typedef struct packed {
        logic [BEAT_W-1:0] idx;
        logic              active;
        logic              last;
    } beat_state_t;

    function automatic logic [1:0] code_to_lg(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

    function automatic logic [BEAT_W-1:0] lg_mask(input logic [1:0] lg);
        return BEAT_W'((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
    import bcg_pkg::*;
(
    input  logic [1:0]  blen_code_i,
    input  logic        btype_i,
    output burst_mode_t mode_o
);
    always_comb begin
        mode_o.lg    = code_to_lg(blen_code_i);
        mode_o.btype = burst_type_e'(btype_i);
    end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
    import bcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [1:0]  lg_i,
    output beat_state_t state_o
);
    logic [BEAT_W-1:0] idx_q;
    logic              active_q;
    logic              at_last;

    assign at_last = active_q && (idx_q == lg_mask(lg_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (start_i) begin
            idx_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (at_last) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_o.idx    = idx_q;
        state_o.active = active_q;
        state_o.last   = at_last;
    end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  burst_mode_t       mode_i,
    input  logic [BEAT_W-1:0] idx_i,
    output logic [COL_W-1:0]  col_o
);
    localparam int HI_W = COL_W - BEAT_W;

    logic [BEAT_W-1:0] mask;
    logic [BEAT_W-1:0] seed;
    logic [BEAT_W-1:0] offs;
    logic [BEAT_W-1:0] low;

    always_comb begin
        mask = lg_mask(mode_i.lg);
        seed = base_i[BEAT_W-1:0];
        if (mode_i.btype == BT_INTLV) begin
            offs = seed ^ idx_i;
        end else begin
            offs = seed + idx_i;
        end
        low   = (seed & ~mask) | (offs & mask);
        col_o = {base_i[COL_W-1:BEAT_W], low};
    end

    if (HI_W < 1) begin : g_bad_width
        initial $error("COL_W must exceed the in-block width");
    end
endmodule

// File: rtl/bcg_burst_addr_gen.sv
module bcg_burst_addr_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       blen_code_i,
    input  logic             btype_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             busy_o
);
    burst_mode_t      mode_in;
    burst_mode_t      mode_q;
    logic [COL_W-1:0] base_q;
    beat_state_t      beat;

    bcg_mode_decode u_decode (
        .blen_code_i (blen_code_i),
        .btype_i     (btype_i),
        .mode_o      (mode_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{lg: 2'd1, btype: BT_SEQ};
            base_q <= '0;
        end else if (start_i) begin
            mode_q <= mode_in;
            base_q <= start_col_i;
        end
    end

    bcg_beat_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .lg_i    (mode_q.lg),
        .state_o (beat)
    );

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base_i (base_q),
        .mode_i (mode_q),
        .idx_i  (beat.idx),
        .col_o  (col_o)
    );

    assign beat_valid_o = beat.active;
    assign last_o       = beat.last;
    assign busy_o       = start_i | beat.active;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_valid_o,
    input logic             last_o,
    input logic             busy_o
);
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (beat_valid_o && col_o == $past(start_col_i)));  // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !beat_valid_o);  // R2

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        last_o |-> beat_valid_o);  // R2

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !start_i) |=>
            (!beat_valid_o || col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));  // R5

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o || start_i) |-> busy_o);  // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!beat_valid_o && !start_i) |-> (!busy_o && !last_o));  // R1
endmodule

bind bcg_burst_addr_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .col_o        (col_o),
    .beat_valid_o (beat_valid_o),
    .last_o       (last_o),
    .busy_o       (busy_o)
);

// File: tb/bcg_burst_addr_gen_tb.sv
module bcg_burst_addr_gen_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       blen_code_i = 2'd0;
    logic             btype_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_valid_o;
    logic             last_o;
    logic             busy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    bcg_burst_addr_gen #(.COL_W(COL_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .blen_code_i  (blen_code_i),
        .btype_i      (btype_i),
        .col_o        (col_o),
        .beat_valid_o (beat_valid_o),
        .last_o       (last_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'd0) ? 2 : (1 << code);
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                                 input logic [1:0] code,
                                                 input logic typ, input int k);
        int L = len_of(code);
        int lo = int'(s) % L;
        int nl = typ ? (lo ^ k) : ((lo + k) % L);
        return COL_W'((int'(s) / L) * L + nl);
    endfunction

    // Drive a strobe at a negedge; return at the negedge where beat 0 shows.
    task automatic strobe(input logic [COL_W-1:0] s, input logic [1:0] code, input logic typ);
        start_col_i = s;
        blen_code_i = code;
        btype_i     = typ;
        start_i     = 1'b1;
        #1;
        chk("R9 busy in strobe cycle", busy_o, 1'b1);
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    // Check beats from first_k to the end, then idle.
    task automatic follow(input logic [COL_W-1:0] s, input logic [1:0] code,
                          input logic typ, input int first_k, input string req);
        int L = len_of(code);
        for (int k = first_k; k < L; k++) begin
            chk({req, " col"}, col_o, exp_col(s, code, typ, k));
            chk("R2 valid", beat_valid_o, 1'b1);
            chk("R2 last", last_o, (k == L - 1));
            chk("R9 busy", busy_o, 1'b1);
            @(negedge clk);
            #1;
        end
        chk("R2 ends", beat_valid_o, 1'b0);
        chk("R9 idle", busy_o, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 valid", beat_valid_o, 1'b0);
        chk("R1 last", last_o, 1'b0);
        chk("R1 busy", busy_o, 1'b0);
    endtask

    task automatic t_seq();
        strobe(10'h2A5, 2'd3, 1'b0);
        chk("R6 beat0", col_o, 10'h2A5);
        follow(10'h2A5, 2'd3, 1'b0, 0, "R3 seq8");
        strobe(10'h107, 2'd2, 1'b0);
        follow(10'h107, 2'd2, 1'b0, 0, "R3 seq4");
        strobe(10'h3FF, 2'd1, 1'b0);
        follow(10'h3FF, 2'd1, 1'b0, 0, "R5 seq2 top");
    endtask

    task automatic t_intlv();
        strobe(10'h0C5, 2'd3, 1'b1);
        follow(10'h0C5, 2'd3, 1'b1, 0, "R4 il8");
        strobe(10'h1F2, 2'd2, 1'b1);
        follow(10'h1F2, 2'd2, 1'b1, 0, "R4 il4");
        strobe(10'h061, 2'd1, 1'b1);
        follow(10'h061, 2'd1, 1'b1, 0, "R4 il2");
    endtask

    task automatic t_reserved();
        strobe(10'h013, 2'd0, 1'b0);
        follow(10'h013, 2'd0, 1'b0, 0, "R2 code0");
    endtask

    task automatic t_ignore();
        strobe(10'h236, 2'd3, 1'b0);
        start_col_i = 10'h001;
        blen_code_i = 2'd1;
        btype_i     = 1'b1;
        follow(10'h236, 2'd3, 1'b0, 0, "R8 held");
    endtask

    task automatic t_restart();
        strobe(10'h154, 2'd3, 1'b0);
        follow_part: for (int k = 0; k < 3; k++) begin
            chk("R7 pre col", col_o, exp_col(10'h154, 2'd3, 1'b0, k));
            if (k < 2) begin
                @(negedge clk);
                #1;
            end
        end
        strobe(10'h2EB, 2'd3, 1'b1);
        chk("R7 new beat0", col_o, 10'h2EB);
        follow(10'h2EB, 2'd3, 1'b1, 0, "R7 restart");
    endtask

    task automatic t_on_last();
        strobe(10'h09D, 2'd2, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
        end
        chk("R7 at last", last_o, 1'b1);
        strobe(10'h30A, 2'd1, 1'b1);
        chk("R9 no gap", busy_o, 1'b1);
        follow(10'h30A, 2'd1, 1'b1, 0, "R7 back2back");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        @(negedge clk);
        t_seq();
        t_intlv();
        t_reserved();
        t_ignore();
        t_restart();
        t_on_last();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule